// File: doc/BRIEF.md
# Raster Timing and Vertical-Blank Interrupt Generator

This block paces a video frame of 341 dots by 262 lines, one dot per clock of the video clock. It reports the current dot and line, and flags whether the beam is in the 256 by 240 picture area, in horizontal blanking, or in vertical blanking. A processor running at one third of the video rate gets a clock-enable strobe on every third dot.

When the beam reaches line 241, a sticky vertical-blank flag is raised. The flag drives an active-low interrupt request to the processor whenever an enable bit allows it. The processor can clear the flag early by reading status. Otherwise the flag drops at the pre-render line 261. The processor services the request through its non-maskable interrupt vector. There is no data stream through this block, so every pin is a plain control or status level.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `dot`=0, `line`=0, `vbl_flag`=0, `nmi_n`=1 and `cpu_ce`=0.
- R2: `dot` advances by one on every clock edge and goes from 340 back to 0.
- R3: `line` advances by one on the edge where `dot` goes from 340 to 0, and goes from 261 back to 0 on that edge.
- R4: `visible` is 1 exactly when `dot`<256 and `line`<240. `hblank` is 1 exactly when `dot`>=256. `vblank` is 1 exactly when `line`>=240.
- R5: `cpu_ce` is 1 exactly in the cycles whose count of clock edges since reset release, taken modulo 3, equals 2.
- R6: `vbl_flag` first reads 1 in the cycle where the counters show line 241, dot 1.
- R7: `vbl_flag` first reads 0 in the cycle where the counters show line 261, dot 1.
- R8: If `status_rd` is 1 at a clock edge, `vbl_flag` is 0 after that edge. The exception is the edge that sets the flag (line 241, dot 0 to dot 1): there the set wins and the flag reads 1.
- R9: `nmi_n` is 0 exactly when `vbl_flag` and `nmi_en` are both 1, in the same cycle and with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_en | input | 1 | Allows the vertical-blank flag to raise the interrupt |
| status_rd | input | 1 | One-cycle strobe: the processor has read status; clears the flag |
| dot | output | 9 | Current dot within the line, 0 to 340 |
| line | output | 9 | Current line within the frame, 0 to 261 |
| visible | output | 1 | Beam is inside the 256x240 picture area |
| hblank | output | 1 | Beam is at dots 256 to 340 |
| vblank | output | 1 | Beam is at lines 240 to 261 |
| vbl_flag | output | 1 | Sticky vertical-blank status bit |
| nmi_n | output | 1 | Active-low interrupt request to the processor |
| cpu_ce | output | 1 | Processor clock enable, one cycle in every three |

## Verification
The counters, the divider strobe and the flag are registered, so each changes one edge after the condition that causes it. The bench counts the edges since reset release and samples on the falling edge. It predicts the set at 241/1, the clear at 261/1 and a read clear as due one cycle after the triggering counter value or strobe. The picture and blank decodes and `nmi_n` are combinational, so they are checked in the same cycle: for `nmi_en`, one time step after it is driven, before any edge. The bench walks two full frames so that it can check the read that coincides with the set edge.

// File: rtl/raster_pkg.sv
package raster_pkg;
  parameter int DOTS_PER_LINE   = 341;
  parameter int LINES_PER_FRAME = 262;
  parameter int PIC_DOTS        = 256;
  parameter int PIC_LINES       = 240;
  parameter int VBL_SET_LINE    = 241;
  parameter int PRE_RENDER_LINE = 261;
  parameter int CE_RATIO        = 3;
endpackage

// File: rtl/raster_counters.sv
module raster_counters #(
  parameter int DOTS  = raster_pkg::DOTS_PER_LINE,
  parameter int LINES = raster_pkg::LINES_PER_FRAME,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          line_end
);
  localparam logic [DW-1:0] DOT_LAST  = DW'(DOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  assign line_end = (dot == DOT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dot  <= '0;
      line <= '0;
    end else if (line_end) begin
      dot  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      dot <= dot + 1'b1;
    end
  end
endmodule

// File: rtl/raster_ce_div.sv
module raster_ce_div #(
  parameter int RATIO = raster_pkg::CE_RATIO,
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);
  generate
    if (RATIO <= 1) begin : g_pass
      assign ce = rst_n;
    end else begin : g_div
      localparam logic [PW-1:0] PH_LAST = PW'(RATIO - 1);
      logic [PW-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rst_n)               phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                      phase <= phase + 1'b1;
      end
      assign ce = (phase == PH_LAST);
    end
  endgenerate
endmodule

// File: rtl/raster_vbl_ctl.sv
module raster_vbl_ctl #(
  parameter int DW       = 9,
  parameter int LW       = 9,
  parameter int SET_LINE = raster_pkg::VBL_SET_LINE,
  parameter int CLR_LINE = raster_pkg::PRE_RENDER_LINE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dot,
  input  logic [LW-1:0] line,
  input  logic          nmi_en,
  input  logic          status_rd,
  output logic          vbl_flag,
  output logic          nmi_n
);
  localparam logic [LW-1:0] SET_L = LW'(SET_LINE);
  localparam logic [LW-1:0] CLR_L = LW'(CLR_LINE);

  logic at_line_start, set_hit, clr_hit;
  assign at_line_start = (dot == '0);
  assign set_hit = at_line_start && (line == SET_L);
  assign clr_hit = at_line_start && (line == CLR_L);

  always_ff @(posedge clk) begin
    if (!rst_n)                    vbl_flag <= 1'b0;
    else if (set_hit)              vbl_flag <= 1'b1;
    else if (clr_hit || status_rd) vbl_flag <= 1'b0;
  end

  assign nmi_n = ~(vbl_flag & nmi_en);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int DOTS      = raster_pkg::DOTS_PER_LINE,
  parameter int LINES     = raster_pkg::LINES_PER_FRAME,
  parameter int PIC_DOTS  = raster_pkg::PIC_DOTS,
  parameter int PIC_LINES = raster_pkg::PIC_LINES,
  parameter int SET_LINE  = raster_pkg::VBL_SET_LINE,
  parameter int CLR_LINE  = raster_pkg::PRE_RENDER_LINE,
  parameter int CE_RATIO  = raster_pkg::CE_RATIO,
  localparam int DW = $clog2(DOTS),
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_en,
  input  logic          status_rd,
  output logic [DW-1:0] dot,
  output logic [LW-1:0] line,
  output logic          visible,
  output logic          hblank,
  output logic          vblank,
  output logic          vbl_flag,
  output logic          nmi_n,
  output logic          cpu_ce
);
  localparam logic [DW-1:0] PD = DW'(PIC_DOTS);
  localparam logic [LW-1:0] PL = LW'(PIC_LINES);

  logic line_end;

  raster_counters #(.DOTS(DOTS), .LINES(LINES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .line_end(line_end)
  );

  raster_ce_div #(.RATIO(CE_RATIO)) u_ce (
    .clk(clk), .rst_n(rst_n), .ce(cpu_ce)
  );

  raster_vbl_ctl #(.DW(DW), .LW(LW), .SET_LINE(SET_LINE), .CLR_LINE(CLR_LINE)) u_vbl (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .nmi_en(nmi_en),
    .status_rd(status_rd), .vbl_flag(vbl_flag), .nmi_n(nmi_n)
  );

  assign hblank  = (dot >= PD);
  assign vblank  = (line >= PL);
  assign visible = !hblank && !vblank;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int DW = 9,
  parameter int LW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nmi_en,
  input logic          status_rd,
  input logic [DW-1:0] dot,
  input logic [LW-1:0] line,
  input logic          visible,
  input logic          hblank,
  input logic          vblank,
  input logic          vbl_flag,
  input logic          nmi_n,
  input logic          cpu_ce
);
  a_r2_dot_range: assert property (@(posedge clk) disable iff (!rst_n) dot <= DW'(340));
  a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    dot == DW'(340) |=> dot == '0);
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (dot == DW'(340) && line == LW'(261)) |=> line == '0);
  a_r4_visible_excl: assert property (@(posedge clk) disable iff (!rst_n)
    visible |-> (!hblank && !vblank));
  a_r5_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);
  a_r6_vbl_set: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LW'(241) && dot == '0) |=> vbl_flag);
  a_r7_vbl_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LW'(261) && dot == '0) |=> !vbl_flag);
  a_r8_read_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !(line == LW'(241) && dot == '0)) |=> !vbl_flag);
  a_r9_nmi_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> (vbl_flag && nmi_en));
endmodule

bind raster_timing_gen raster_timing_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en), .status_rd(status_rd),
  .dot(dot), .line(line), .visible(visible), .hblank(hblank), .vblank(vblank),
  .vbl_flag(vbl_flag), .nmi_n(nmi_n), .cpu_ce(cpu_ce)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int FRAME = 341 * 262;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_en = 1'b0;
  logic status_rd = 1'b0;
  logic [8:0] dot, line;
  logic visible, hblank, vblank, vbl_flag, nmi_n, cpu_ce;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  raster_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .nmi_en(nmi_en), .status_rd(status_rd),
    .dot(dot), .line(line), .visible(visible), .hblank(hblank), .vblank(vblank),
    .vbl_flag(vbl_flag), .nmi_n(nmi_n), .cpu_ce(cpu_ce)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic go_to(input int target);
    while (cyc < target) tick();
  endtask

  task automatic check_pos();
    chk("R2 dot", int'(dot), cyc % 341);
    chk("R3 line", int'(line), (cyc / 341) % 262);
  endtask

  task automatic t_reset();
    chk("R1 dot", int'(dot), 0);
    chk("R1 line", int'(line), 0);
    chk("R1 flag", int'(vbl_flag), 0);
    chk("R1 nmi_n", int'(nmi_n), 1);
    chk("R1 ce", int'(cpu_ce), 0);
    chk("R4 visible at 0/0", int'(visible), 1);
  endtask

  task automatic t_ce();
    for (int i = 0; i < 9; i++) begin
      chk("R5 cpu_ce", int'(cpu_ce), (cyc % 3 == 2) ? 1 : 0);
      tick();
    end
  endtask

  task automatic t_line_wrap();
    go_to(339);
    check_pos();
    chk("R4 hblank at 339", int'(hblank), 1);
    tick();
    check_pos();
    tick();
    check_pos();
    chk("R2 dot wrap", int'(dot), 0);
    chk("R3 line step", int'(line), 1);
    chk("R4 hblank off", int'(hblank), 0);
  endtask

  task automatic t_regions();
    go_to(239 * 341 + 255);
    check_pos();
    chk("R4 visible last pixel", int'(visible), 1);
    chk("R4 vblank off", int'(vblank), 0);
    tick();
    chk("R4 hblank at 256", int'(hblank), 1);
    chk("R4 visible off", int'(visible), 0);
    go_to(240 * 341);
    check_pos();
    chk("R4 vblank at line 240", int'(vblank), 1);
    chk("R4 visible in vblank", int'(visible), 0);
    chk("R6 flag not yet", int'(vbl_flag), 0);
  endtask

  task automatic t_vbl_set();
    go_to(241 * 341);
    chk("R6 flag at 241/0", int'(vbl_flag), 0);
    chk("R9 nmi_n idle", int'(nmi_n), 1);
    tick();
    check_pos();
    chk("R6 flag at 241/1", int'(vbl_flag), 1);
    chk("R9 nmi_n asserted", int'(nmi_n), 0);
  endtask

  task automatic t_nmi_gate();
    nmi_en = 1'b0;
    #1;
    chk("R9 nmi_n masked", int'(nmi_n), 1);
    chk("R9 flag kept", int'(vbl_flag), 1);
    tick();
    nmi_en = 1'b1;
    #1;
    chk("R9 nmi_n reasserted", int'(nmi_n), 0);
  endtask

  task automatic t_vbl_clear();
    go_to(261 * 341);
    chk("R7 flag held to 261/0", int'(vbl_flag), 1);
    tick();
    chk("R7 flag cleared 261/1", int'(vbl_flag), 0);
    chk("R7 nmi_n released", int'(nmi_n), 1);
    go_to(FRAME - 1);
    check_pos();
    tick();
    check_pos();
    chk("R3 frame wrap line", int'(line), 0);
  endtask

  task automatic t_read();
    go_to(FRAME + 241 * 341);
    status_rd = 1'b1;
    tick();
    chk("R8 set beats read", int'(vbl_flag), 1);
    tick();
    status_rd = 1'b0;
    chk("R8 read clears", int'(vbl_flag), 0);
    chk("R9 nmi_n after read", int'(nmi_n), 1);
    for (int i = 0; i < 5; i++) tick();
    chk("R8 stays clear", int'(vbl_flag), 0);
    check_pos();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog cyc=%0d actual=running expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    nmi_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dot in reset", int'(dot), 0);
    chk("R1 flag in reset", int'(vbl_flag), 0);
    rst_n = 1'b1;
    cyc = 0;
    t_reset();
    t_ce();
    t_line_wrap();
    t_regions();
    t_vbl_set();
    t_nmi_gate();
    t_vbl_clear();
    t_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule